// File: doc/BRIEF.md
# MSI Capture Ring-Buffer Controller

This block turns incoming message-signalled interrupt events into 16-byte records written into a ring buffer in system memory. Each record carries the interrupt number in its first four bytes, least significant byte first. The other twelve bytes are zero. A level interrupt to the host stays asserted while the ring holds records that software has not yet consumed.

Software sets the block up through a small word-addressed register file. The registers are a control word, a 64-bit ring base address split into two halves, a read offset owned by software, and a raw write offset owned by hardware. A 2-bit control field sets the ring size to 32, 64, 128 or 256 KB. The raw write offset only ever counts upward, so both the block and software reduce it with the mask `(size-1) & ~0xF` before comparing it with the read offset. With full detection on, a full ring either drops new events and records a sticky overflow flag, or overwrites the oldest record and pushes the read offset forward.

Capture is driven by a three-state machine:

- `ST_OFF` is the disabled state. It moves to `ST_IDLE` once the enable bit is set.
- `ST_IDLE` waits for an event. An accepted event moves it to `ST_WRITE`. A dropped event keeps it in `ST_IDLE`. Clearing the enable bit returns it to `ST_OFF`.
- `ST_WRITE` holds a memory write request. It returns to `ST_IDLE` when the memory port accepts the request, or to `ST_OFF` when the enable bit is cleared.

Top module: `msi_ring_ctrl`

## Requirements
- R1: After reset, every register reads zero, and `irq`, `evt_ready` and `mem_req` are low.
- R2: Register word offsets are: control 0x0, base high 0x3, base low 0x4, read offset 0x5, write offset 0x6. Other offsets read zero. The control word bits are:
  - bit 0: enable
  - bit 1: full detection
  - bit 3: interrupt enable
  - bit 4: stop when full
  - bits 9:8: size code
  - bit 16: overflow, read-only

  All writable fields read back as written.
- R3: Each record is written at address `{base_hi,base_lo}` plus the masked write offset. Byte k of the record appears on `mem_data[8k+7:8k]`. Bytes 0 to 3 hold the interrupt number, little-endian, and bytes 4 to 15 are zero.
- R4: `evt_ready` is high only in `ST_IDLE` with the block enabled. During a pending write, `mem_req`, `mem_addr` and `mem_data` stay stable until `mem_ready`, and `evt_ready` stays low.
- R5: The raw write offset increases by 16 for each accepted memory write and does not wrap. It may read back larger than the ring size.
- R6: With size code n, the ring holds `2^(15+n)` bytes. Both offsets are compared under the mask `(2^(15+n)-1) & ~0xF`, and the write address wraps to the base at the ring end.
- R7: `irq` is high exactly when enable and interrupt enable are both set and the masked write offset differs from the masked read offset.
- R8: Full means that advancing the masked write offset by 16 would equal the masked read offset, and full detection is on. If the ring is full and stop-when-full is set, the next event is accepted but no memory write follows, the write offset stays unchanged, and the overflow bit sets and stays set.
- R9: If the ring is full and stop-when-full is clear, the record is written and the read offset advances by 16 (masked), so the ring stays full and `irq` stays high.
- R10: Clearing enable drops `evt_ready`, `mem_req` and `irq`, and events offered while disabled are ignored. A control write that takes enable from 0 to 1 clears both offsets and the overflow bit.
- R11: Writes to the write-offset register are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from `reg_addr`) |
| evt_valid | input | 1 | MSI event present |
| evt_num | input | 32 | Interrupt number of the event |
| evt_ready | output | 1 | Event accepted when high with `evt_valid` |
| mem_req | output | 1 | Memory write request |
| mem_addr | output | 64 | Byte address of the record |
| mem_data | output | 128 | Record contents, byte k on bits 8k+7:8k |
| mem_ready | input | 1 | Memory accepts the request this cycle |
| irq | output | 1 | Level interrupt, unread records present |

## Verification
If the capture state machine is left in the wrong state, the ports show it on the very next cycle. It appears either as `evt_ready` high while a record is still outstanding, or as a request that vanishes before `mem_ready`. A write offset or mask held wrong appears on `mem_addr` at the next record, and on `irq` as soon as the offsets are compared. Sweeps that run the ring past its end at two sizes make a wrong wrap point show within one record of the boundary. A lost overflow flag or a missing read-offset push shows up in the register readback right after the first event at a full ring.

// File: rtl/msi_ring_pkg.sv
package msi_ring_pkg;

    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_IDLE  = 2'd1,
        ST_WRITE = 2'd2
    } cap_state_t;

    localparam logic [2:0] REG_CTRL    = 3'd0;
    localparam logic [2:0] REG_BASE_HI = 3'd3;
    localparam logic [2:0] REG_BASE_LO = 3'd4;
    localparam logic [2:0] REG_RD_OFF  = 3'd5;
    localparam logic [2:0] REG_WR_OFF  = 3'd6;

    localparam int CB_EN   = 0;
    localparam int CB_FULL = 1;
    localparam int CB_IRQ  = 3;
    localparam int CB_STOP = 4;
    localparam int CB_SZ   = 8;
    localparam int CB_OVF  = 16;

    localparam int RING_MIN_SHIFT = 15;
    localparam int ENTRY_BYTES    = 16;

    function automatic logic [31:0] ring_mask(input logic [1:0] sz);
        logic [31:0] span;
        span = 32'd1 << (RING_MIN_SHIFT + int'(sz));
        return (span - 32'd1) & ~32'(ENTRY_BYTES - 1);
    endfunction

endpackage

// File: rtl/msi_ring_regs.sv
module msi_ring_regs
    import msi_ring_pkg::*;
#(
    parameter int REG_W = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_we,
    input  logic [2:0]           reg_addr,
    input  logic [REG_W-1:0]     reg_wdata,
    output logic [REG_W-1:0]     reg_rdata,
    input  logic                 commit,
    input  logic                 push_rd,
    input  logic                 set_ovf,
    output logic                 en,
    output logic                 irq_en,
    output logic                 stop_full,
    output logic                 ring_full,
    output logic                 ring_nonempty,
    output logic [2*REG_W-1:0]   wr_addr
);
    localparam int ADDR_W = 2 * REG_W;

    logic             ctrl_en, ctrl_full, ctrl_irq, ctrl_stop, ovf;
    logic [1:0]       ctrl_sz;
    logic [REG_W-1:0] base_hi, base_lo, wr_raw, rd_raw;
    logic [REG_W-1:0] mask, wr_m, rd_m, wr_next_m, rd_next_m;
    logic             ctrl_wr, en_rise;

    always_comb begin
        mask      = ring_mask(ctrl_sz);
        wr_m      = wr_raw & mask;
        rd_m      = rd_raw & mask;
        wr_next_m = (wr_m + REG_W'(ENTRY_BYTES)) & mask;
        rd_next_m = (rd_m + REG_W'(ENTRY_BYTES)) & mask;
        ring_full     = ctrl_full && (wr_next_m == rd_m);
        ring_nonempty = (wr_m != rd_m);
        ctrl_wr   = reg_we && (reg_addr == REG_CTRL);
        en_rise   = ctrl_wr && reg_wdata[CB_EN] && !ctrl_en;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_en   <= 1'b0;
            ctrl_full <= 1'b0;
            ctrl_irq  <= 1'b0;
            ctrl_stop <= 1'b0;
            ctrl_sz   <= 2'd0;
            ovf       <= 1'b0;
            base_hi   <= '0;
            base_lo   <= '0;
            wr_raw    <= '0;
            rd_raw    <= '0;
        end else begin
            if (ctrl_wr) begin
                ctrl_en   <= reg_wdata[CB_EN];
                ctrl_full <= reg_wdata[CB_FULL];
                ctrl_irq  <= reg_wdata[CB_IRQ];
                ctrl_stop <= reg_wdata[CB_STOP];
                ctrl_sz   <= reg_wdata[CB_SZ+1:CB_SZ];
            end
            if (reg_we && reg_addr == REG_BASE_HI) base_hi <= reg_wdata;
            if (reg_we && reg_addr == REG_BASE_LO) base_lo <= reg_wdata;

            if (en_rise)     wr_raw <= '0;
            else if (commit) wr_raw <= wr_raw + REG_W'(ENTRY_BYTES);

            if (en_rise)                                  rd_raw <= '0;
            else if (reg_we && reg_addr == REG_RD_OFF)    rd_raw <= reg_wdata;
            else if (push_rd)                             rd_raw <= rd_next_m;

            if (en_rise)      ovf <= 1'b0;
            else if (set_ovf) ovf <= 1'b1;
        end
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            REG_CTRL: begin
                reg_rdata[CB_EN]          = ctrl_en;
                reg_rdata[CB_FULL]        = ctrl_full;
                reg_rdata[CB_IRQ]         = ctrl_irq;
                reg_rdata[CB_STOP]        = ctrl_stop;
                reg_rdata[CB_SZ+1:CB_SZ]  = ctrl_sz;
                reg_rdata[CB_OVF]         = ovf;
            end
            REG_BASE_HI: reg_rdata = base_hi;
            REG_BASE_LO: reg_rdata = base_lo;
            REG_RD_OFF:  reg_rdata = rd_raw;
            REG_WR_OFF:  reg_rdata = wr_raw;
            default:     reg_rdata = '0;
        endcase
    end

    assign en        = ctrl_en;
    assign irq_en    = ctrl_irq;
    assign stop_full = ctrl_stop;
    assign wr_addr   = {base_hi, base_lo} + ADDR_W'(wr_m);

    // R9: a committed record under full detection never leaves the ring looking empty
    assert_commit_leaves_entry_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && ctrl_full && !reg_we) |=> ring_nonempty);

endmodule

// File: rtl/msi_ring_fsm.sv
module msi_ring_fsm
    import msi_ring_pkg::*;
#(
    parameter int NUM_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             ring_full,
    input  logic             stop_full,
    input  logic             evt_valid,
    input  logic [NUM_W-1:0] evt_num,
    output logic             evt_ready,
    input  logic             mem_ready,
    output logic             mem_req,
    output logic             commit,
    output logic             push_rd,
    output logic             set_ovf,
    output logic [NUM_W-1:0] num_q
);
    cap_state_t state_q, state_d;
    logic       accept, drop;

    assign accept = evt_valid && evt_ready;
    assign drop   = ring_full && stop_full;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF:   if (en) state_d = ST_IDLE;
            ST_IDLE:  if (!en) state_d = ST_OFF;
                      else if (accept && !drop) state_d = ST_WRITE;
            ST_WRITE: if (!en) state_d = ST_OFF;
                      else if (mem_ready) state_d = ST_IDLE;
            default:  state_d = ST_OFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                num_q <= '0;
        else if (accept && !drop)  num_q <= evt_num;
    end

    always_comb begin
        evt_ready = (state_q == ST_IDLE) && en;
        mem_req   = (state_q == ST_WRITE) && en;
        commit    = mem_req && mem_ready;
        push_rd   = commit && ring_full;
        set_ovf   = accept && drop;
    end

    // R4: an outstanding request holds with the same record until accepted
    assert_req_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready && en) |=> (mem_req && $stable(num_q)));

    // R4: an accepted, non-dropped event produces a request next cycle
    assert_accept_starts_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !drop) |=> (mem_req || !en));

    // R8: a dropped event produces no memory write
    assert_drop_no_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && drop) |=> !mem_req);

    // R10: a disabled block neither accepts nor requests
    assert_off_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!evt_ready && !mem_req));

endmodule

// File: rtl/msi_ring_ctrl.sv
module msi_ring_ctrl
    import msi_ring_pkg::*;
#(
    parameter int REG_W   = 32,
    parameter int NUM_W   = 32,
    parameter int ENTRY_W = 8 * ENTRY_BYTES
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_we,
    input  logic [2:0]           reg_addr,
    input  logic [REG_W-1:0]     reg_wdata,
    output logic [REG_W-1:0]     reg_rdata,
    input  logic                 evt_valid,
    input  logic [NUM_W-1:0]     evt_num,
    output logic                 evt_ready,
    output logic                 mem_req,
    output logic [2*REG_W-1:0]   mem_addr,
    output logic [ENTRY_W-1:0]   mem_data,
    input  logic                 mem_ready,
    output logic                 irq
);
    logic             en, irq_en, stop_full, ring_full, ring_nonempty;
    logic             commit, push_rd, set_ovf;
    logic [NUM_W-1:0] num_q;

    msi_ring_regs #(.REG_W(REG_W)) u_regs (
        .clk           (clk),
        .rst_n         (rst_n),
        .reg_we        (reg_we),
        .reg_addr      (reg_addr),
        .reg_wdata     (reg_wdata),
        .reg_rdata     (reg_rdata),
        .commit        (commit),
        .push_rd       (push_rd),
        .set_ovf       (set_ovf),
        .en            (en),
        .irq_en        (irq_en),
        .stop_full     (stop_full),
        .ring_full     (ring_full),
        .ring_nonempty (ring_nonempty),
        .wr_addr       (mem_addr)
    );

    msi_ring_fsm #(.NUM_W(NUM_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .ring_full (ring_full),
        .stop_full (stop_full),
        .evt_valid (evt_valid),
        .evt_num   (evt_num),
        .evt_ready (evt_ready),
        .mem_ready (mem_ready),
        .mem_req   (mem_req),
        .commit    (commit),
        .push_rd   (push_rd),
        .set_ovf   (set_ovf),
        .num_q     (num_q)
    );

    assign mem_data = {{(ENTRY_W-NUM_W){1'b0}}, num_q};
    assign irq      = en && irq_en && ring_nonempty;

    // R3: the record address holds while the request waits
    assert_addr_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready && !reg_we) |=> $stable(mem_addr));

endmodule

// File: tb/sim_msi_ring_ctrl.sv
module sim_msi_ring_ctrl;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         reg_we = 1'b0;
    logic [2:0]   reg_addr = 3'd0;
    logic [31:0]  reg_wdata = '0;
    logic [31:0]  reg_rdata;
    logic         evt_valid = 1'b0;
    logic [31:0]  evt_num = '0;
    logic         evt_ready;
    logic         mem_req;
    logic [63:0]  mem_addr;
    logic [127:0] mem_data;
    logic         mem_ready = 1'b0;
    logic         irq;

    int n_chk = 0;
    int n_bad = 0;
    logic [63:0] base = 64'h1234_5678_9ABC_0000;

    always #4 clk = ~clk;

    msi_ring_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_valid(evt_valid),
        .evt_num(evt_num), .evt_ready(evt_ready), .mem_req(mem_req),
        .mem_addr(mem_addr), .mem_data(mem_data), .mem_ready(mem_ready), .irq(irq)
    );

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd_reg(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic wait_ready(input string req);
        int n = 0;
        @(negedge clk);
        while (!evt_ready && n < 50) begin
            @(negedge clk);
            n++;
        end
        if (n >= 50) chk(req, 0, 1);
    endtask

    task automatic do_event(input logic [31:0] num, input logic [63:0] exp_addr,
                            input int delay, input bit chk_data);
        wait_ready("R4");
        evt_valid = 1'b1; evt_num = num;
        @(negedge clk);
        evt_valid = 1'b0;
        chk("R4", mem_req, 1'b1);
        if (chk_data) begin
            chk("R3", mem_addr, exp_addr);
            chk("R3", mem_data, {96'd0, num});
        end
        for (int k = 0; k < delay; k++) begin
            @(negedge clk);
            chk("R4", {mem_req, evt_ready}, 2'b10);
            chk("R4", mem_addr, exp_addr);
            chk("R4", mem_data, {96'd0, num});
        end
        mem_ready = 1'b1;
        @(negedge clk);
        mem_ready = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] d;
        logic [31:0] wm;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset values
        foreach (d[i]) begin end
        for (int a = 0; a < 8; a++) begin
            rd_reg(3'(a), d);
            chk("R1", d, 0);
        end
        chk("R1", {irq, evt_ready, mem_req}, 3'b000);

        // R2: register map and readback
        wr_reg(3'd3, base[63:32]);
        wr_reg(3'd4, base[31:0]);
        rd_reg(3'd3, d); chk("R2", d, base[63:32]);
        rd_reg(3'd4, d); chk("R2", d, base[31:0]);
        rd_reg(3'd1, d); chk("R2", d, 0);
        wr_reg(3'd0, 32'h0000_031B);
        rd_reg(3'd0, d); chk("R2", d, 32'h0000_031B);
        wr_reg(3'd0, 32'h0);
        wr_reg(3'd0, 32'h0000_0009);
        rd_reg(3'd0, d); chk("R2", d, 32'h0000_0009);

        // R11: write offset register ignores writes
        wr_reg(3'd6, 32'h40);
        rd_reg(3'd6, d); chk("R11", d, 0);

        // R3 R5 R7: size 0, free-running wrap past the ring end
        for (int i = 0; i < 2050; i++) begin
            logic [31:0] num;
            num = 32'(i) * 32'h9E37_79B1 + 32'd1;
            do_event(num, base + 64'((32'(i) * 16) & 32'h7FF0), i % 3, 1'b1);
            wm = (32'(i + 1) * 16) & 32'h7FF0;
            chk("R7", irq, wm != 0);
        end
        rd_reg(3'd6, d); chk("R5", d, 32'h8020);

        // R7: software drain and interrupt enable
        wr_reg(3'd5, 32'h8020);
        chk("R7", irq, 1'b0);
        wr_reg(3'd5, 32'h30);
        chk("R7", irq, 1'b1);
        wr_reg(3'd0, 32'h1);
        chk("R7", irq, 1'b0);
        wr_reg(3'd0, 32'h9);
        chk("R7", irq, 1'b1);

        // R6 R10: other ring sizes, offsets cleared on enable rise
        for (int sz = 1; sz < 4; sz++) begin
            wr_reg(3'd0, 32'h0);
            wr_reg(3'd0, 32'h9 | (32'(sz) << 8));
            rd_reg(3'd6, d); chk("R10", d, 0);
            rd_reg(3'd5, d); chk("R10", d, 0);
            if (sz == 1) begin
                for (int i = 0; i < 4097; i++)
                    do_event(32'(i) ^ 32'h00C0_FFEE,
                             base + 64'((32'(i) * 16) & 32'hFFF0), 0, 1'b1);
                rd_reg(3'd6, d); chk("R6", d, 32'h10010);
                wr_reg(3'd5, 32'h0);
            end
            wr_reg(3'd5, 32'h10 + (32'd1 << (15 + sz)));
            chk("R6", irq, sz == 1 ? 1'b0 : 1'b1);
            wr_reg(3'd5, 32'd1 << (15 + sz));
            chk("R6", irq, sz == 1 ? 1'b1 : 1'b0);
            wr_reg(3'd5, 32'd1 << (14 + sz));
            chk("R6", irq, 1'b1);
        end

        // R8: fill a 32 KB ring with stop-when-full
        wr_reg(3'd0, 32'h0);
        wr_reg(3'd0, 32'h1B);
        for (int i = 0; i < 2047; i++)
            do_event(32'(i) + 32'h100, base + 64'(32'(i) * 16), 0, 1'b1);
        rd_reg(3'd0, d); chk("R8", d, 32'h1B);
        chk("R8", irq, 1'b1);
        wait_ready("R8");
        evt_valid = 1'b1; evt_num = 32'hDEAD;
        @(negedge clk);
        evt_valid = 1'b0;
        for (int k = 0; k < 3; k++) begin
            chk("R8", mem_req, 1'b0);
            @(negedge clk);
        end
        rd_reg(3'd0, d); chk("R8", d, 32'h1001B);
        rd_reg(3'd6, d); chk("R8", d, 32'h7FF0);
        chk("R8", irq, 1'b1);

        // R9: overwrite when full
        wr_reg(3'd0, 32'h0B);
        rd_reg(3'd0, d); chk("R8", d, 32'h1000B);
        do_event(32'hBEEF, base + 64'h7FF0, 1, 1'b1);
        rd_reg(3'd5, d); chk("R9", d, 32'h10);
        rd_reg(3'd6, d); chk("R9", d, 32'h8000);
        chk("R9", irq, 1'b1);

        // R10: disable, ignored events, re-enable clears
        wr_reg(3'd0, 32'h0);
        chk("R10", {irq, evt_ready, mem_req}, 3'b000);
        evt_valid = 1'b1; evt_num = 32'h77;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk("R10", {evt_ready, mem_req}, 2'b00);
        end
        evt_valid = 1'b0;
        rd_reg(3'd6, d); chk("R10", d, 32'h8000);
        wr_reg(3'd0, 32'h9);
        rd_reg(3'd0, d); chk("R10", d, 32'h9);
        rd_reg(3'd6, d); chk("R10", d, 0);
        rd_reg(3'd5, d); chk("R10", d, 0);
        chk("R10", irq, 1'b0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule